// File: doc/BRIEF.md
# Strobed Watchdog Timer with Timeout Write Lock

This block is a countdown watchdog that runs from a slow time base. An enable pulse from a 32,768 Hz oscillator arrives once per oscillator period in the system clock domain. A free-running prescaler divides it so that the countdown advances 32 times per second. The host programs a 6-bit timeout. It must then kick the timer by writing the strobe bit before the count reaches zero. If the count does reach zero, the block raises a sticky timeout flag and a one-cycle expiry pulse, which the interrupt logic may use.

A single host write carries three things: a strobe (kick) bit, a lock bit and the timeout field. The lock bit is registered. The value left by the previous write decides whether the timeout field of the current write is taken. This lets a host that has locked the timer keep kicking it without any chance of altering the programmed timeout. A stored timeout of zero switches the watchdog off. The flag is cleared when the host completes a read of the flags register, which is signalled by a one-cycle input.

Top module: `strobe_wdt`

## Requirements
- R1: The countdown takes one step after every DIV pulses of `osc_tick_i` (default 1024, giving 32 Hz). Clock cycles without a pulse do not advance the prescaler, and host writes leave its phase unchanged.
- R2: After a reload with value N (1 to 63), the edge that takes the N-th step drives `wdt_expire_o` high for exactly one cycle and sets `wdt_flag_o`.
- R3: A write with bit 7 (strobe) at 1 reloads the countdown with the stored timeout and restarts it, so a timer kicked before zero does not expire.
- R4: Bits 5:0 of a write replace the stored timeout only when the stored lock state is 0. An accepted timeout write also reloads and restarts the countdown. When the lock state is 1, these bits have no effect.
- R5: Bit 6 of every write is stored as the lock state. It takes effect from the next write onward, and it is 0 after reset.
- R6: A stored timeout of 0 disables the watchdog. No expiry or flag occurs, even when the timer is kicked.
- R7: `wdt_flag_o` stays set until a cycle with `rd_clr_i` high. When an expiry and a clear fall in the same cycle, the flag ends that cycle set.
- R8: After an expiry the countdown rests at zero. No further expiry occurs until a strobe or an accepted timeout write.
- R9: After reset the flag and the expiry pulse are low, the stored timeout is 0 (disabled) and the lock state is 0.
- R10: A write that reloads the countdown takes priority over a step that falls in the same cycle, so that step cannot cause an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick_i | input | 1 | One-cycle enable per oscillator period |
| wr_en_i | input | 1 | Host write to the watchdog register |
| wr_data_i | input | TOV_W+2 | Bit 7 strobe, bit 6 lock, bits 5:0 timeout (default widths) |
| rd_clr_i | input | 1 | Completed host read of the flags register |
| wdt_flag_o | output | 1 | Sticky timeout flag |
| wdt_expire_o | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The hardest case to reach is a reload that lands in the very cycle that would take the final step. The write has to be placed on the last oscillator pulse of a prescaler period. The bench gets there by driving oscillator pulses back to back from a known prescaler phase and issuing the write on the final pulse. It uses the same alignment to make a flag clear coincide with an expiry. Lock transitions are reached by writing sequences in which the lock bit and the timeout field disagree. A behavioural model compared on every clock checks the flag and the pulse throughout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic load;     // timeout field accepted
    logic kick;     // strobe bit set
  } wdt_cmd_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DIV = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_tick_i,
  output logic step_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pcnt_q;

  assign step_o = osc_tick_i && (pcnt_q == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
    end else if (osc_tick_i) begin
      if (step_o) pcnt_q <= '0;
      else        pcnt_q <= pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter int TOV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [TOV_W+1:0] wr_data_i,
  output wdt_cmd_t         cmd_o,
  output logic [TOV_W-1:0] reload_val_o,
  output logic [TOV_W-1:0] tov_q
);
  localparam int LOCK_BIT = TOV_W;
  localparam int KICK_BIT = TOV_W + 1;

  logic lock_q;

  always_comb begin
    cmd_o.load   = wr_en_i && !lock_q;
    cmd_o.kick   = wr_en_i && wr_data_i[KICK_BIT];
    reload_val_o = cmd_o.load ? wr_data_i[TOV_W-1:0] : tov_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tov_q  <= '0;
      lock_q <= 1'b0;
    end else if (wr_en_i) begin
      lock_q <= wr_data_i[LOCK_BIT];
      if (!lock_q) tov_q <= wr_data_i[TOV_W-1:0];
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int TOV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             reload_i,
  input  logic [TOV_W-1:0] reload_val_i,
  input  logic             rd_clr_i,
  output logic [TOV_W-1:0] cnt_q,
  output logic             flag_o,
  output logic             expire_o
);
  logic hit;

  assign hit = !reload_i && step_i && (cnt_q == TOV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      flag_o   <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= hit;
      if (reload_i)                      cnt_q <= reload_val_i;
      else if (step_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      if (hit)           flag_o <= 1'b1;
      else if (rd_clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/strobe_wdt.sv
module strobe_wdt
  import wdt_pkg::*;
#(
  parameter int DIV   = 1024,
  parameter int TOV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick_i,
  input  logic             wr_en_i,
  input  logic [TOV_W+1:0] wr_data_i,
  input  logic             rd_clr_i,
  output logic             wdt_flag_o,
  output logic             wdt_expire_o
);
  logic             step;
  wdt_cmd_t         cmd;
  logic [TOV_W-1:0] reload_val;
  logic [TOV_W-1:0] tov_q;
  logic [TOV_W-1:0] cnt_q;

  wdt_prescaler #(.DIV(DIV)) u_presc (
    .clk        (clk),
    .rst        (rst),
    .osc_tick_i (osc_tick_i),
    .step_o     (step)
  );

  wdt_ctrl_reg #(.TOV_W(TOV_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .cmd_o        (cmd),
    .reload_val_o (reload_val),
    .tov_q        (tov_q)
  );

  wdt_counter #(.TOV_W(TOV_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .step_i       (step),
    .reload_i     (cmd.load || cmd.kick),
    .reload_val_i (reload_val),
    .rd_clr_i     (rd_clr_i),
    .cnt_q        (cnt_q),
    .flag_o       (wdt_flag_o),
    .expire_o     (wdt_expire_o)
  );
endmodule

// File: rtl/strobe_wdt_checker.sv
module strobe_wdt_checker #(
  parameter int TOV_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_clr,
  input logic             flag,
  input logic             expire,
  input logic [TOV_W-1:0] tov,
  input logic [TOV_W-1:0] cnt
);
  a_r2_expire_sets_flag: assert property (@(posedge clk) disable iff (rst)
    expire |-> flag);

  a_r2_expire_single_cycle: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !rd_clr) |=> flag);

  a_r6_disabled_no_expire: assert property (@(posedge clk) disable iff (rst)
    (tov == '0) |-> !expire);

  a_r8_rest_at_zero: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !wr_en) |=> (cnt == '0 && !expire));

  a_r9_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!flag && !expire && tov == '0));
endmodule

bind strobe_wdt strobe_wdt_checker #(.TOV_W(TOV_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en_i),
  .rd_clr (rd_clr_i),
  .flag   (wdt_flag_o),
  .expire (wdt_expire_o),
  .tov    (tov_q),
  .cnt    (cnt_q)
);

// File: tb/strobe_wdt_bench.sv
module strobe_wdt_bench;
  localparam int DIV   = 4;
  localparam int TOV_W = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_clr = 1'b0;
  logic       flag, expire;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  strobe_wdt #(.DIV(DIV), .TOV_W(TOV_W)) u_strobe_wdt (
    .clk(clk), .rst(rst), .osc_tick_i(osc), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_clr_i(rd_clr),
    .wdt_flag_o(flag), .wdt_expire_o(expire)
  );

  // behavioural reference model
  int m_p, m_lock, m_tov, m_cnt, m_flag, m_exp;
  always @(posedge clk) begin
    bit stp, set;
    if (rst) begin
      m_p = 0; m_lock = 0; m_tov = 0; m_cnt = 0; m_flag = 0; m_exp = 0;
    end else begin
      stp = osc && (m_p == DIV - 1);
      if (osc) m_p = stp ? 0 : m_p + 1;
      set = 0;
      if (wr_en) begin
        if (m_lock == 0) m_tov = int'(wr_data[5:0]);
        if (m_lock == 0 || wr_data[7]) m_cnt = m_tov;
        m_lock = int'(wr_data[6]);
      end else if (stp && m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) set = 1;
      end
      m_exp = set;
      if (set) m_flag = 1;
      else if (rd_clr) m_flag = 0;
    end
    #1;
    if (!rst && !done) begin
      checks++;
      if (flag !== m_flag[0] || expire !== m_exp[0]) begin
        failures++;
        $display("FAIL R2 R7 model compare: flag=%0b exp=%0b expected flag=%0d exp=%0d",
                 flag, expire, m_flag, m_exp);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic steps(input int n);
    if (n > 0) begin
      osc = 1'b1;
      repeat (n * DIV) @(negedge clk);
      osc = 1'b0;
    end
  endtask

  task automatic clr;
    rd_clr = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 flag after reset", flag, 1'b0);
    chk("R9 expire after reset", expire, 1'b0);

    // R1, R2: timeout 2 = 8 osc pulses, idle cycles in between
    wr(8'h02);
    steps(1);
    repeat (5) @(negedge clk);
    osc = 1'b1; repeat (DIV - 1) @(negedge clk); osc = 1'b0;
    chk("R1 no expiry one pulse short", expire, 1'b0);
    steps(0);
    osc = 1'b1; @(negedge clk); osc = 1'b0;
    chk("R2 expiry pulse on final step", expire, 1'b1);
    chk("R2 flag set", flag, 1'b1);
    @(negedge clk);
    chk("R2 pulse lasts one cycle", expire, 1'b0);

    // R8 / R7: rests at zero, flag sticky
    steps(3);
    chk("R8 no re-expiry at zero", expire, 1'b0);
    chk("R7 flag sticky", flag, 1'b1);
    clr();
    chk("R7 flag cleared by read", flag, 1'b0);

    // R3 with lock: timeout 5 locked, kick with field 0
    wr(8'h45);
    steps(4);
    wr(8'hC0);
    steps(4);
    chk("R3 kicked timer not expired", flag, 1'b0);
    steps(1);
    chk("R3 expiry after stored 5 steps", flag, 1'b1);
    clr();

    // R4 / R5: locked writes ignored, lock taken from previous write
    wr(8'h41);
    steps(6);
    chk("R4 locked timeout write ignored", flag, 1'b0);
    wr(8'h01);
    steps(2);
    chk("R5 lock from previous write blocks field", flag, 1'b0);
    wr(8'h02);
    steps(1);
    chk("R4 accepted write reloads", flag, 1'b0);
    steps(1);
    chk("R4 accepted timeout 2 expires", flag, 1'b1);
    clr();

    // R6: zero disables a running countdown and kicks
    wr(8'h03);
    steps(1);
    wr(8'h00);
    steps(5);
    wr(8'h80);
    steps(70);
    chk("R6 disabled timer never expires", flag, 1'b0);

    // R10: reload on the cycle of the final step
    wr(8'h02);
    steps(1);
    osc = 1'b1; repeat (DIV - 1) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h82;
    @(negedge clk);
    wr_en = 1'b0; osc = 1'b0;
    chk("R10 write beats expiring step", expire, 1'b0);
    steps(1);
    chk("R10 reloaded count still running", flag, 1'b0);
    steps(1);
    chk("R10 expiry after reload", flag, 1'b1);
    clr();

    // R7: expiry and clear in same cycle
    wr(8'h01);
    osc = 1'b1; repeat (DIV - 1) @(negedge clk);
    rd_clr = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0; osc = 1'b0;
    chk("R7 set wins over clear", flag, 1'b1);
    clr();

    // R2 boundary: maximum timeout 63
    wr(8'h3F);
    steps(62);
    chk("R2 max timeout not early", flag, 1'b0);
    steps(1);
    chk("R2 max timeout expires at 63", flag, 1'b1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule